// File: doc/BRIEF.md
# Down-Counting Compare Timer

A 32-bit timer that counts down by one on every prescaled tick of a selectable tick source. It is controlled through a small register port with single-cycle writes and combinational reads. Software picks what happens when the count reaches zero. In free-running mode the counter wraps to all ones. In reload mode it starts again from a programmed load value.

A compare register is checked against the counter on every tick. A match sets a sticky flag, which software clears by writing one to it. The flag can drive an interrupt line. A match can also toggle, clear or set an output pin.

When the timer is enabled, it either resumes from the value it held or restarts from its start value. A write to the load register can optionally overwrite the running count at once. One control bit resets every register in the block.

Top module: `cmp_down_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `pin_out` are 0.
- R2: When the timer ticks with the counter at 0 and control bit 3 clear, the counter becomes 0xFFFF_FFFF.
- R3: When the timer ticks with the counter at 0 and control bit 3 set, the counter takes the load register's value.
- R4: While control bit 0 is clear, the counter holds its value.
  - A control write that sets bit 0 from 0 with bit 1 set loads the start value into the counter. The start value is the load register when bit 3 is set, and 0xFFFF_FFFF otherwise.
  - With bit 1 clear, the counter resumes from the value it held.
- R5: A write to the load register (offset 0x08) with control bit 17 set replaces the counter on the same clock edge. With bit 17 clear, the counter is left unchanged.
- R6: Control bits 15:4 hold a divider value N. The counter decrements once every N+1 source ticks.
  - The first decrement comes N+1 cycles after the enabling write.
  - The divider restarts whenever the timer is disabled or the control register is written.
- R7: Control bits 25:24 select the tick source:
  - 00: none
  - 01: `src_tick[0]`
  - 10: `src_tick[1]`
  - 11: `src_tick[2]`
- R8: A tick on which the counter equals the compare register (offset 0x0C) sets status bit 0 (offset 0x04).
  - Writing 1 to status bit 0 clears it. Writing 0 has no effect.
  - A new match in the same cycle as a clearing write wins.
- R9: `irq` is high exactly while status bit 0 and control bit 2 are both set.
- R10: Control bits 23:22 set the pin mode.
  - On a match, mode 01 toggles the pin, mode 10 drives it low and mode 11 drives it high.
  - In mode 00, `pin_out` reads 0.
- R11: A control write with bit 16 set returns every register, the counter, the flag and the pin to their reset values on that edge. Bit 16 always reads 0.
- R12: The registers sit at these offsets: control 0x00, status 0x04, load 0x08, compare 0x0C and counter 0x10.
  - The counter is read-only.
  - Other offsets read 0.
  - Control bits other than 0–15, 17 and 22–25 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Tick enables of the three selectable sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Compare interrupt level |
| pin_out | output | 1 | Compare-driven output pin |

## Verification
On every cycle, the embedded assertions check the following:
- the counter's next value at zero in both wrap modes;
- that the counter holds while no tick arrives;
- the load overwrite;
- the spacing between prescaled ticks;
- flag setting on a match;
- the effect of each pin mode;
- the software reset.

Only the directed scenarios can show the rest:
- the exact cycle of the first decrement after enabling;
- resume versus restart across a disable;
- source selection;
- the clear-by-one flag protocol;
- the register map readback.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int B_EN      = 0;
   localparam int B_ENMODE  = 1;
   localparam int B_IRQEN   = 2;
   localparam int B_RELOAD  = 3;
   localparam int B_PSC_LSB = 4;
   localparam int B_SWRST   = 16;
   localparam int B_OVW     = 17;
   localparam int B_PIN_LSB = 22;
   localparam int B_SRC_LSB = 24;
   localparam int SRC_SEL_W = 2;

   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_STAT = 8'h04;
   localparam logic [7:0] OFF_LOAD = 8'h08;
   localparam logic [7:0] OFF_CMP  = 8'h0C;
   localparam logic [7:0] OFF_CNT  = 8'h10;

   typedef enum logic [1:0] {
      PIN_OFF  = 2'b00,
      PIN_TOG  = 2'b01,
      PIN_LOW  = 2'b10,
      PIN_HIGH = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
   parameter int PSC_W   = 12,
   parameter int NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               clear,
   input  logic [1:0]         src_sel,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [PSC_W-1:0]   div,
   output logic               tick
);
   localparam int NSEL = NUM_SRC + 1;

   logic [NSEL-1:0]  src_vec;
   logic             src_on;
   logic [PSC_W-1:0] pcnt;

   // index 0 is the "no source" selection
   assign src_vec[0] = 1'b0;
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign src_vec[g+1] = src_tick[g];
   end

   always_comb begin
      src_on = 1'b0;
      for (int i = 0; i < NSEL; i++)
         if (int'(src_sel) == i) src_on = src_vec[i];
   end

   assign tick = enable && src_on && (pcnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (clear || !enable) pcnt <= '0;
      else if (src_on)           pcnt <= (pcnt == div) ? '0 : pcnt + 1'b1;
   end

   p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !clear && (div != '0) |=> !tick);
   p_pcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= div);
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             tick,
   input  logic             start,
   input  logic [CNT_W-1:0] start_val,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   input  logic             ovw,
   input  logic [CNT_W-1:0] ovw_val,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt,
   output logic             cmp_evt
);
   assign cmp_evt = tick && (cnt == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (soft_clr) cnt <= '0;
      else if (ovw)      cnt <= ovw_val;
      else if (start)    cnt <= start_val;
      else if (tick)     cnt <= (cnt == '0) ? (reload ? load_val : '1) : cnt - 1'b1;
   end

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (cnt == '0) && !reload && !ovw && !start && !soft_clr |=> cnt == '1);
   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (cnt == '0) && reload && !ovw && !start && !soft_clr |=> cnt == $past(load_val));
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !ovw && !start && !soft_clr |=> $stable(cnt));
   p_ovw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovw && !soft_clr |=> cnt == $past(ovw_val));
endmodule

// File: rtl/cdt_pin.sv
module cdt_pin
   import cdt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      evt,
   input  pin_mode_e mode,
   output logic      pin_o
);
   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pin_q <= 1'b0;
      else if (clr) pin_q <= 1'b0;
      else if (evt) begin
         case (mode)
            PIN_TOG:  pin_q <= ~pin_q;
            PIN_LOW:  pin_q <= 1'b0;
            PIN_HIGH: pin_q <= 1'b1;
            default:  pin_q <= pin_q;
         endcase
      end
   end

   assign pin_o = (mode == PIN_OFF) ? 1'b0 : pin_q;

   p_pin_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !clr && (mode == PIN_HIGH) |=> pin_q);
   p_pin_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !clr && (mode == PIN_LOW) |=> !pin_q);
   p_pin_tog_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !clr && (mode == PIN_TOG) |=> pin_q != $past(pin_q));
endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
   import cdt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PSC_W   = 12,
   parameter int NUM_SRC = 3,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               irq,
   output logic               pin_out
);
   localparam int          DATA_W    = 32;
   localparam logic [31:0] PSC_MASK  = 32'((64'd1 << PSC_W) - 64'd1) << B_PSC_LSB;
   localparam logic [31:0] CTRL_MASK = 32'hF | PSC_MASK | (32'd1 << B_OVW)
                                     | (32'd3 << B_PIN_LSB) | (32'd3 << B_SRC_LSB);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end
   if (PSC_W < 1 || PSC_W > 12) begin : g_bad_psc
      $error("PSC_W must lie in 1..12");
   end
   if (NUM_SRC < 1 || NUM_SRC >= (1 << SRC_SEL_W)) begin : g_bad_src
      $error("NUM_SRC must fit the source select field");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 5..8");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  load_q, cmp_q, cnt;
   logic              flag_q, tick, cmp_evt;
   logic              wr_ctrl, wr_stat, wr_load, wr_cmp, soft_clr, start;
   logic [CNT_W-1:0]  start_val;

   assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFF_CTRL));
   assign wr_stat  = wr_en && (addr == ADDR_W'(OFF_STAT));
   assign wr_load  = wr_en && (addr == ADDR_W'(OFF_LOAD));
   assign wr_cmp   = wr_en && (addr == ADDR_W'(OFF_CMP));
   assign soft_clr = wr_ctrl && wdata[B_SWRST];
   assign start    = wr_ctrl && wdata[B_EN] && !ctrl_q[B_EN] && wdata[B_ENMODE];
   assign start_val = wdata[B_RELOAD] ? load_q : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         cmp_q  <= '0;
         flag_q <= 1'b0;
      end else if (soft_clr) begin
         ctrl_q <= '0;
         load_q <= '0;
         cmp_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
         if (wr_load) load_q <= wdata[CNT_W-1:0];
         if (wr_cmp)  cmp_q  <= wdata[CNT_W-1:0];
         if (cmp_evt)                      flag_q <= 1'b1;
         else if (wr_stat && wdata[0])     flag_q <= 1'b0;
      end
   end

   cdt_prescale #(.PSC_W(PSC_W), .NUM_SRC(NUM_SRC)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl_q[B_EN]),
      .clear    (wr_ctrl),
      .src_sel  (ctrl_q[B_SRC_LSB +: SRC_SEL_W]),
      .src_tick (src_tick),
      .div      (ctrl_q[B_PSC_LSB +: PSC_W]),
      .tick     (tick)
   );

   cdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .tick      (tick),
      .start     (start),
      .start_val (start_val),
      .reload    (ctrl_q[B_RELOAD]),
      .load_val  (load_q),
      .ovw       (wr_load && ctrl_q[B_OVW]),
      .ovw_val   (wdata[CNT_W-1:0]),
      .cmp_val   (cmp_q),
      .cnt       (cnt),
      .cmp_evt   (cmp_evt)
   );

   cdt_pin u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .evt   (cmp_evt),
      .mode  (pin_mode_e'(ctrl_q[B_PIN_LSB +: 2])),
      .pin_o (pin_out)
   );

   assign irq = flag_q && ctrl_q[B_IRQEN];

   always_comb begin
      rdata = '0;
      case (8'(addr))
         OFF_CTRL: rdata = ctrl_q;
         OFF_STAT: rdata = {31'b0, flag_q};
         OFF_LOAD: rdata = 32'(load_q);
         OFF_CMP:  rdata = 32'(cmp_q);
         OFF_CNT:  rdata = 32'(cnt);
         default:  rdata = '0;
      endcase
   end

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt && !soft_clr |=> flag_q);
   p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !soft_clr && !(wr_stat && wdata[0]) |=> flag_q);
   p_soft_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (ctrl_q == '0) && (cnt == '0) && !flag_q && !pin_out);
endmodule

// File: tb/tb_cmp_down_timer.sv
module tb_cmp_down_timer;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                          A_CMP = 5'h0C, A_CNT = 5'h10, A_NONE = 5'h14;
   localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, IRQEN = 32'h4, RLD = 32'h8,
                           SWR = 32'h1_0000, OVW = 32'h2_0000;
   localparam logic [31:0] SRC1 = 32'h0100_0000;

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [2:0]  src_tick = 3'b101;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        irq, pin_out;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   cmp_down_timer dut (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .pin_out(pin_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] psc(int n);  return 32'(n) << 4;  endfunction
   function automatic logic [31:0] om(int m);   return 32'(m) << 22; endfunction
   function automatic logic [31:0] src(int s);  return 32'(s) << 24; endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_reg(string req, logic [4:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset;
      chk_reg("R1 ctrl", A_CTRL, 0); chk_reg("R1 stat", A_STAT, 0);
      chk_reg("R1 load", A_LOAD, 0); chk_reg("R1 cmp", A_CMP, 0);
      chk_reg("R1 cnt", A_CNT, 0);
      check("R1 irq", 32'(irq), 0); check("R1 pin", 32'(pin_out), 0);
   endtask

   task automatic t_reload;
      wr(A_CTRL, SWR); wr(A_LOAD, 5);
      wr(A_CTRL, EN | ENMOD | RLD | SRC1);
      edges(3); chk_reg("R4 restart from load", A_CNT, 2);
      edges(3); chk_reg("R3 reload at zero", A_CNT, 5);
   endtask

   task automatic t_free;
      wr(A_CTRL, SWR);
      wr(A_CTRL, EN | ENMOD | SRC1 | OVW);
      edges(2); chk_reg("R4 restart all ones", A_CNT, 32'hFFFF_FFFD);
      wr(A_LOAD, 1); chk_reg("R5 overwrite", A_CNT, 1);
      edges(1); chk_reg("R2 reach zero", A_CNT, 0);
      edges(1); chk_reg("R2 wrap", A_CNT, 32'hFFFF_FFFF);
   endtask

   task automatic t_noovw;
      wr(A_CTRL, SWR); wr(A_LOAD, 20);
      wr(A_CTRL, EN | ENMOD | RLD | SRC1);
      wr(A_LOAD, 50);
      chk_reg("R5 no overwrite", A_CNT, 19);
      chk_reg("R5 load stored", A_LOAD, 50);
   endtask

   task automatic t_resume;
      wr(A_CTRL, SWR); wr(A_LOAD, 40);
      wr(A_CTRL, EN | ENMOD | RLD | SRC1);
      edges(4); chk_reg("R4 running", A_CNT, 36);
      wr(A_CTRL, RLD | SRC1);
      chk_reg("R4 disable edge", A_CNT, 35);
      edges(5); chk_reg("R4 hold disabled", A_CNT, 35);
      wr(A_CTRL, EN | RLD | SRC1);
      edges(2); chk_reg("R4 resume", A_CNT, 33);
   endtask

   task automatic t_psc;
      wr(A_CTRL, SWR); wr(A_LOAD, 100);
      wr(A_CTRL, EN | ENMOD | RLD | SRC1 | psc(3));
      edges(3); chk_reg("R6 before first", A_CNT, 100);
      edges(1); chk_reg("R6 first decrement", A_CNT, 99);
      edges(3); chk_reg("R6 mid period", A_CNT, 99);
      edges(1); chk_reg("R6 second decrement", A_CNT, 98);
   endtask

   task automatic t_src;
      wr(A_CTRL, SWR); wr(A_LOAD, 30);
      wr(A_CTRL, EN | ENMOD | RLD | src(2));
      edges(3); chk_reg("R7 source 2 idle", A_CNT, 30);
      wr(A_CTRL, EN | RLD | src(3));
      edges(2); chk_reg("R7 source 3 runs", A_CNT, 28);
      wr(A_CTRL, EN | RLD | src(0));
      edges(3); chk_reg("R7 source off", A_CNT, 27);
   endtask

   task automatic t_cmp;
      logic [31:0] base;
      base = EN | ENMOD | RLD | IRQEN | om(1) | SRC1 | OVW;
      wr(A_CTRL, SWR); wr(A_CMP, 7);
      wr(A_CTRL, base);
      wr(A_LOAD, 8);
      edges(1); chk_reg("R8 no match yet", A_STAT, 0);
      check("R10 pin before", 32'(pin_out), 0);
      edges(1); chk_reg("R8 match sets flag", A_STAT, 1);
      check("R9 irq raised", 32'(irq), 1);
      check("R10 toggle high", 32'(pin_out), 1);
      wr(A_STAT, 0); chk_reg("R8 write 0 ignored", A_STAT, 1);
      wr(A_STAT, 1); chk_reg("R8 write 1 clears", A_STAT, 0);
      check("R9 irq cleared", 32'(irq), 0);
      edges(7); chk_reg("R8 second match", A_STAT, 1);
      check("R10 toggle low", 32'(pin_out), 0);
      wr(A_CTRL, base & ~IRQEN);
      check("R9 irq gated", 32'(irq), 0);
      chk_reg("R9 flag kept", A_STAT, 1);
   endtask

   task automatic t_pin;
      wr(A_CTRL, SWR); wr(A_CMP, 7);
      wr(A_CTRL, EN | ENMOD | RLD | om(3) | SRC1 | OVW);
      wr(A_LOAD, 8);
      edges(2); check("R10 set mode", 32'(pin_out), 1);
      wr(A_CTRL, EN | RLD | om(0) | SRC1 | OVW);
      check("R10 off reads 0", 32'(pin_out), 0);
      wr(A_CTRL, EN | RLD | om(2) | SRC1 | OVW);
      check("R10 held before match", 32'(pin_out), 1);
      wr(A_LOAD, 8);
      edges(2); check("R10 clear mode", 32'(pin_out), 0);
   endtask

   task automatic t_swr;
      wr(A_CTRL, SWR); wr(A_CMP, 7);
      wr(A_CTRL, EN | ENMOD | RLD | IRQEN | om(3) | SRC1 | OVW);
      wr(A_LOAD, 8);
      edges(2); check("R11 setup irq", 32'(irq), 1);
      wr(A_CTRL, SWR | 32'hF);
      chk_reg("R11 ctrl", A_CTRL, 0); chk_reg("R11 stat", A_STAT, 0);
      chk_reg("R11 load", A_LOAD, 0); chk_reg("R11 cmp", A_CMP, 0);
      chk_reg("R11 cnt", A_CNT, 0);
      check("R11 irq", 32'(irq), 0); check("R11 pin", 32'(pin_out), 0);
      edges(3); chk_reg("R11 stays stopped", A_CNT, 0);
   endtask

   task automatic t_map;
      wr(A_CTRL, SWR);
      wr(A_CNT, 123); chk_reg("R12 counter read-only", A_CNT, 0);
      wr(A_NONE, 32'hDEAD_BEEF); chk_reg("R12 unmapped reads 0", A_NONE, 0);
      chk_reg("R12 unmapped write harmless", A_LOAD, 0);
      wr(A_CMP, 32'h1234_5678); chk_reg("R12 compare offset", A_CMP, 32'h1234_5678);
      wr(A_CTRL, 32'hFFFE_FFFF); chk_reg("R12 control mask", A_CTRL, 32'h03C2_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset; t_reload; t_free; t_noovw; t_resume; t_psc;
      t_src; t_cmp; t_pin; t_swr; t_map;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule